// File: doc/BRIEF.md
# Quadrature Subcarrier QPSK Modulator

The block turns an already encoded serial bit stream into a digital QPSK sample stream on a subcarrier, one signed 10-bit word per sample clock, ready for a DAC. Bits are taken in pairs. The first bit of a pair steers the sign of a cosine subcarrier and the second steers the sign of a sine subcarrier. The two signed products are added into a single output word.

Both subcarriers come from one phase counter that addresses a sinusoid table of 24 samples per subcarrier cycle. A second counter groups four subcarrier cycles into one 96-sample symbol. The modulator asks for data with a bit-request strobe shortly before each symbol boundary. It latches the new pair only at the boundary and flags the first sample of each symbol with a one-cycle marker.

A small state machine sequences start-up. `ST_SILENT` is the state after reset: the output is zero and no pair has been collected. It moves to `ST_PRIMED` once the second bit of a pair has been taken, and the output stays zero. At the next symbol boundary it moves to `ST_RUN`, where it stays until reset and modulates every symbol.

Top module: `qpsk_subcarrier_mod`

## Requirements
- R1: While `rst` is high (synchronous, active high), `sample_out` is zero and `sym_start` and `bit_req` are low from the first clock edge on.
- R2: The phase address counts 0 to 23 and wraps to 0. The cycle count advances at each wrap and wraps after 3, so one symbol lasts 96 sample clocks.
- R3: The sine table magnitudes for addresses 0 to 6 are 0, 93, 181, 255, 313, 349 and 361. The second quarter mirrors the first and the second half is the negated first half. Cosine at address a equals sine at address (a+6) mod 24.
- R4: Each active sample equals (I ? +cos : -cos) + (Q ? +sin : -sin) at the current address, in two's complement on 10 bits, and its magnitude never exceeds 510.
- R5: `bit_req` is high for exactly two single cycles per symbol, at symbol sample 80 and symbol sample 88 (cycle count 3, addresses 8 and 16). `bit_in` is sampled on the clock edge where `bit_req` is high. The first bit of the pair is I and the second is Q.
- R6: A new I/Q pair takes effect only at a symbol boundary (address 0 and cycle count 0). All 96 samples of a symbol use the same pair.
- R7: `sym_start` is high on exactly the first sample of each active symbol and low on every other sample.
- R8: After reset, `sample_out` stays zero for the first 96 samples. The first active symbol starts at sample 96 and uses the first two bits requested.
- R9: `bit_in` has no effect while `bit_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_in | input | 1 | Serial data bit, sampled when `bit_req` is high |
| bit_req | output | 1 | Bit-request strobe, two pulses per symbol |
| sample_out | output | 10 | Signed QPSK sample |
| sym_start | output | 1 | High on the first sample of each symbol |

## Verification
The assertions assume that reset is held for at least one clock edge before any check counts. They also assume that `bit_in` is a clean 0 or 1 on each edge where `bit_req` is high. The stimulus presents data only in response to the strobe, from the falling edge after the strobe appears. Between requests it drives changing junk on `bit_in`, so the rule that the pin is ignored is exercised without breaking what the checks assume. Reset is applied at start-up and again in the middle of an active symbol, which brings the design back to its silent state.

// File: rtl/qpsk_pkg.sv
package qpsk_pkg;

    typedef enum logic [1:0] {
        ST_SILENT = 2'd0,
        ST_PRIMED = 2'd1,
        ST_RUN    = 2'd2
    } mod_state_t;

    // Rounded 361*sin(k*15deg) for a quarter cycle of six steps.
    function automatic int quarter_mag(input int k);
        case (k)
            0:       quarter_mag = 0;
            1:       quarter_mag = 93;
            2:       quarter_mag = 181;
            3:       quarter_mag = 255;
            4:       quarter_mag = 313;
            5:       quarter_mag = 349;
            6:       quarter_mag = 361;
            default: quarter_mag = 0;
        endcase
    endfunction

endpackage

// File: rtl/qpsk_phase_gen.sv
module qpsk_phase_gen #(
    parameter int SPC        = 24,
    parameter int CPS        = 4,
    parameter int REQ_I_ADDR = 8,
    parameter int REQ_Q_ADDR = 16,
    localparam int AW = $clog2(SPC),
    localparam int CW = $clog2(CPS)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [AW-1:0] addr,
    output logic          boundary,
    output logic          bit_req,
    output logic          take_i,
    output logic          take_q
);
    localparam logic [AW-1:0] A_LAST = AW'(SPC - 1);
    localparam logic [CW-1:0] C_LAST = CW'(CPS - 1);
    localparam logic [AW-1:0] A_REQI = AW'(REQ_I_ADDR);
    localparam logic [AW-1:0] A_REQQ = AW'(REQ_Q_ADDR);

    logic [CW-1:0] cyc;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
            cyc  <= '0;
        end else if (addr == A_LAST) begin
            addr <= '0;
            cyc  <= (cyc == C_LAST) ? '0 : cyc + 1'b1;
        end else begin
            addr <= addr + 1'b1;
        end
    end

    always_comb begin
        boundary = (addr == '0) && (cyc == '0);
        take_i   = (cyc == C_LAST) && (addr == A_REQI);
        take_q   = (cyc == C_LAST) && (addr == A_REQQ);
        bit_req  = take_i || take_q;
    end

    // R2: address wraps to zero after the last table entry
    a_r2_addr_wrap: assert property (@(posedge clk) disable iff (rst)
        (addr == A_LAST) |=> (addr == '0));

    // R5: requests are single-cycle pulses
    a_r5_req_pulse: assert property (@(posedge clk) disable iff (rst)
        bit_req |=> !bit_req);

endmodule

// File: rtl/qpsk_wave_rom.sv
module qpsk_wave_rom
    import qpsk_pkg::*;
#(
    parameter int SPC   = 24,
    parameter int AMP_W = 10,
    localparam int AW  = $clog2(SPC),
    localparam int QTR = SPC / 4
) (
    input  logic [AW-1:0]           addr,
    output logic signed [AMP_W-1:0] sin_s,
    output logic signed [AMP_W-1:0] cos_s
);
    function automatic int wave_at(input int a);
        int quad;
        int pos;
        int mag;
        quad = a / QTR;
        pos  = a % QTR;
        mag  = quad[0] ? quarter_mag(QTR - pos) : quarter_mag(pos);
        wave_at = quad[1] ? -mag : mag;
    endfunction

    always_comb begin
        sin_s = AMP_W'(wave_at(int'(addr)));
        cos_s = AMP_W'(wave_at((int'(addr) + QTR) % SPC));
    end

endmodule

// File: rtl/qpsk_symbol_fsm.sv
module qpsk_symbol_fsm
    import qpsk_pkg::*;
#(
    parameter int AMP_W = 10,
    parameter int OUT_W = 10,
    parameter int PEAK  = 510
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    boundary,
    input  logic                    take_i,
    input  logic                    take_q,
    input  logic                    bit_in,
    input  logic signed [AMP_W-1:0] sin_s,
    input  logic signed [AMP_W-1:0] cos_s,
    output logic signed [OUT_W-1:0] sample_out,
    output logic                    sym_start
);
    mod_state_t state, state_nxt;
    logic nxt_i, nxt_q;
    logic pair_i, pair_q;
    logic go, sel_i, sel_q;
    logic signed [OUT_W:0] term_i, term_q, sum_w;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_SILENT;
        else     state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_SILENT: if (take_q)   state_nxt = ST_PRIMED;
            ST_PRIMED: if (boundary) state_nxt = ST_RUN;
            ST_RUN:                  state_nxt = ST_RUN;
            default:                 state_nxt = ST_SILENT;
        endcase
    end

    always_comb begin
        go     = boundary ? (state != ST_SILENT) : (state == ST_RUN);
        sel_i  = boundary ? nxt_i : pair_i;
        sel_q  = boundary ? nxt_q : pair_q;
        term_i = sel_i ? (OUT_W+1)'(cos_s) : -(OUT_W+1)'(cos_s);
        term_q = sel_q ? (OUT_W+1)'(sin_s) : -(OUT_W+1)'(sin_s);
        sum_w  = term_i + term_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            nxt_i      <= 1'b0;
            nxt_q      <= 1'b0;
            pair_i     <= 1'b0;
            pair_q     <= 1'b0;
            sample_out <= '0;
            sym_start  <= 1'b0;
        end else begin
            if (take_i) nxt_i <= bit_in;
            if (take_q) nxt_q <= bit_in;
            if (boundary && state != ST_SILENT) begin
                pair_i <= nxt_i;
                pair_q <= nxt_q;
            end
            sample_out <= go ? sum_w[OUT_W-1:0] : '0;
            sym_start  <= boundary && (state != ST_SILENT);
        end
    end

    // R8: no output while silent
    a_r8_silent_zero: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SILENT) |=> (sample_out == '0));

    // R7: marker lasts a single sample
    a_r7_single_marker: assert property (@(posedge clk) disable iff (rst)
        sym_start |=> !sym_start);

    // R6: pair held inside a symbol
    a_r6_pair_hold: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && !boundary) |=> ($stable(pair_i) && $stable(pair_q)));

    // R4: output magnitude bound
    a_r4_peak: assert property (@(posedge clk) disable iff (rst)
        (int'(sample_out) <= PEAK) && (int'(sample_out) >= -PEAK));

endmodule

// File: rtl/qpsk_subcarrier_mod.sv
module qpsk_subcarrier_mod
    import qpsk_pkg::*;
#(
    parameter int SPC        = 24,
    parameter int CPS        = 4,
    parameter int REQ_I_ADDR = 8,
    parameter int REQ_Q_ADDR = 16,
    parameter int AMP_W      = 10,
    parameter int OUT_W      = 10,
    localparam int AW = $clog2(SPC)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bit_in,
    output logic                    bit_req,
    output logic signed [OUT_W-1:0] sample_out,
    output logic                    sym_start
);
    logic [AW-1:0]           addr;
    logic                    boundary, take_i, take_q;
    logic signed [AMP_W-1:0] sin_s, cos_s;

    qpsk_phase_gen #(
        .SPC(SPC), .CPS(CPS), .REQ_I_ADDR(REQ_I_ADDR), .REQ_Q_ADDR(REQ_Q_ADDR)
    ) u_phase (
        .clk(clk), .rst(rst), .addr(addr), .boundary(boundary),
        .bit_req(bit_req), .take_i(take_i), .take_q(take_q)
    );

    qpsk_wave_rom #(.SPC(SPC), .AMP_W(AMP_W)) u_rom (
        .addr(addr), .sin_s(sin_s), .cos_s(cos_s)
    );

    qpsk_symbol_fsm #(.AMP_W(AMP_W), .OUT_W(OUT_W)) u_fsm (
        .clk(clk), .rst(rst), .boundary(boundary), .take_i(take_i),
        .take_q(take_q), .bit_in(bit_in), .sin_s(sin_s), .cos_s(cos_s),
        .sample_out(sample_out), .sym_start(sym_start)
    );

endmodule

// File: tb/test_qpsk_subcarrier_mod.sv
`timescale 1ns/1ps
module test_qpsk_subcarrier_mod;
    localparam int SYM = 96;
    localparam int NV  = 8;
    // {I,Q} per symbol
    localparam logic [1:0] VEC [NV] = '{2'b11, 2'b00, 2'b10, 2'b01,
                                        2'b01, 2'b11, 2'b10, 2'b00};
    localparam int MAG [7] = '{0, 93, 181, 255, 313, 349, 361};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_in = 1'b0;
    logic bit_req;
    logic signed [9:0] sample_out;
    logic sym_start;
    int nchk = 0;
    int nfail = 0;
    int b = 0;

    always #2 clk = ~clk;

    qpsk_subcarrier_mod i_qpsk_subcarrier_mod (
        .clk(clk), .rst(rst), .bit_in(bit_in), .bit_req(bit_req),
        .sample_out(sample_out), .sym_start(sym_start)
    );

    function automatic int ref_sin(input int a0);
        int a;
        a = a0 % 24;
        if (a <= 6)       return MAG[a];
        else if (a <= 12) return MAG[12 - a];
        else if (a <= 18) return -MAG[a - 12];
        else              return -MAG[24 - a];
    endfunction

    function automatic int ref_sample(input logic [1:0] p, input int a);
        int c, s;
        c = ref_sin(a + 6);
        s = ref_sin(a);
        return (p[1] ? c : -c) + (p[0] ? s : -s);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic feed(input int n, input logic [1:0] seqv [NV], input bit use_ones);
        if (bit_req) begin
            if (use_ones)       bit_in = 1'b1;
            else if (b / 2 < NV) bit_in = (b % 2 == 0) ? seqv[b/2][1] : seqv[b/2][0];
            else                bit_in = 1'b0;
            b++;
        end else begin
            bit_in = n[1] ^ n[0]; // junk while not requested (R9)
        end
    endtask

    initial begin
        #800000;
        nfail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R1 sample", int'(sample_out), 0);
        chk("R1 marker", int'(sym_start), 0);
        chk("R1 req", int'(bit_req), 0);
        rst = 1'b0;

        // vector walk: each symbol from the table
        for (int n = 0; n < SYM * (NV + 1); n++) begin
            int j, s, ph, exp_v;
            @(negedge clk);
            ph = (n + 1) % SYM;
            chk("R5 req timing", int'(bit_req), (ph == 80 || ph == 88) ? 1 : 0);
            if (n < SYM) begin
                chk("R8 silent", int'(sample_out), 0);
                chk("R7 marker", int'(sym_start), 0);
            end else begin
                j = (n - SYM) % SYM;
                s = (n - SYM) / SYM;
                exp_v = ref_sample(VEC[s], j % 24);
                chk("R3 R4 R6 R9 sample", int'(sample_out), exp_v);
                chk("R2 R7 marker", int'(sym_start), (j == 0) ? 1 : 0);
            end
            feed(n, VEC, 1'b0);
        end

        // directed: reset in mid symbol
        repeat (13) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 mid reset sample", int'(sample_out), 0);
        chk("R1 mid reset marker", int'(sym_start), 0);
        chk("R1 mid reset req", int'(bit_req), 0);
        rst = 1'b0;
        b = 0;
        for (int n = 0; n <= SYM + 6; n++) begin
            @(negedge clk);
            if (n < SYM) begin
                if (sample_out != 0 || sym_start != 0) chk("R8 post reset silent", int'(sample_out), 0);
            end else if (n == SYM) begin
                chk("R8 first symbol start", int'(sym_start), 1);
                chk("R4 cos peak at 0", int'(sample_out), 361);
            end else if (n == SYM + 3) begin
                chk("R4 peak 45deg", int'(sample_out), 510);
                chk("R7 marker low", int'(sym_start), 0);
            end else if (n == SYM + 6) begin
                chk("R3 quarter offset", int'(sample_out), 361);
            end
            feed(n, VEC, 1'b1);
        end

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule